// File: doc/BRIEF.md
# Two-Step Sequenced System Reset Controller

This block produces the system reset outputs of a processor board after a two-step write sequence to one control register. The first write stores a select value and arms the block. The second write carries the same select value with bit 2 set, and that write fires the reset. When select bit 1 is set, the controller pulses the processor reset, the PCI reset and the legacy expansion-bus reset drive together. When bit 1 is clear, it pulses only the processor INIT line.

The register is reachable in two ways. The first is I/O port 0xCF9. The second is a pair of memory addresses at the top of the 32-bit space, 0xFFFFFFF0 and 0xFFFFFFF4. The memory pair exists for a remote agent that can issue memory writes but not I/O writes. That agent writes the arm value to the lower address and the trigger value to the upper one.

Writes enter on a valid/ready port. A write transfers on a rising clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the initiator must hold the address, data and space flag stable. The controller drops `wr_ready` for as long as any reset output is active, so no write can land in the middle of a pulse. The stored select bits are always visible on a plain read pin.

Top module: `sysreset_seq`

## Requirements
- R1: A transferred write whose bit 2 is 0 to the register (I/O space at 0xCF9, or memory space at 0xFFFFFFF0 or 0xFFFFFFF4) stores data bits 1:0 as the select value and arms the block. It asserts no reset output.
- R2: When the block is armed with select 2'b10, a register write of 0x06 asserts `cpu_reset_o`, `pci_reset_o` and `xbus_reset_o` together. They go high in the cycle after the transfer, stay high for the effective hard length, and deassert in the same cycle. `cpu_init_o` stays low.
- R3: When the block is armed with select 2'b00, a register write of 0x04 asserts only `cpu_init_o`, for exactly 4 cycles starting the cycle after the transfer.
- R4: Memory-space writes of 0x02 to 0xFFFFFFF0 and then 0x06 to 0xFFFFFFF4 produce the same hard reset as the I/O sequence.
- R5: A register write with bit 2 set while the block is not armed asserts no reset output.
- R6: A register write with bit 2 set whose bits 1:0 differ from the stored select asserts nothing and disarms the block. A later matching trigger then also asserts nothing.
- R7: Writes to other addresses, and writes in the wrong space (memory at 0xCF9, I/O at 0xFFFFFFF0), neither disarm the block nor change the stored select.
- R8: The effective hard length is `hard_len`, raised to 16 when `hard_len` is below 16.
- R9: `wr_ready` is low while any reset output is high. A write held on the port during that time is not taken.
- R10: `sel_rd_o` reads the stored select in bits 1:0, with bit 2 and all higher bits 0. Power-on reset (`por_n` low) clears the select to 0 and disarms the block.
- R11: Only data bits 2:0 are decoded. Bits 31:3 of a register write have no effect.
- R12: Firing a reset disarms the block. A repeated trigger write after the pulse asserts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write can be taken; low during any reset pulse |
| wr_addr | input | 32 | Write address (I/O or memory) |
| wr_data | input | 32 | Write data; bits 2:0 decoded |
| wr_is_io | input | 1 | 1 = I/O space write, 0 = memory space write |
| hard_len | input | 8 | Requested hard-reset length in cycles |
| sel_rd_o | output | 8 | Read value of the control register |
| cpu_reset_o | output | 1 | Processor reset, active high |
| pci_reset_o | output | 1 | PCI bus reset, active high |
| xbus_reset_o | output | 1 | Legacy expansion-bus reset drive, active high |
| cpu_init_o | output | 1 | Processor INIT pulse, active high |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, an 8-bit length input, a minimum hard length of 16 and an INIT length of 4. These values put both the I/O port and the two top-of-memory alias addresses within reach. The bench drives `hard_len` at 20 to measure a plain pulse width and at 5 to reach the clamp to 16. An 8-bit length keeps every pulse short, so the back-pressure window can be observed from end to end.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_HARD = 2'd1,
    RK_SOFT = 2'd2
  } rst_kind_e;

  localparam int unsigned SEL_W    = 2;
  localparam int unsigned TRIG_BIT = 2;
  localparam int unsigned HARD_BIT = 1;
  localparam int unsigned NUM_PULSE = 2;
endpackage

// File: rtl/rsc_decode.sv
module rsc_decode #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IO_W     = 16,
  parameter logic [15:0] IO_ADDR  = 16'hCF9,
  parameter logic [31:0] MEM_LO   = 32'hFFFF_FFF0,
  parameter logic [31:0] MEM_HI   = 32'hFFFF_FFF4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_io,
  output logic              hit
);
  localparam int unsigned N_MEM = 2;

  logic              io_hit;
  logic [N_MEM-1:0]  mem_hit;

  assign io_hit = is_io
               && (addr[ADDR_W-1:IO_W] == '0)
               && (addr[IO_W-1:0] == IO_ADDR[IO_W-1:0]);

  for (genvar g = 0; g < N_MEM; g++) begin : g_alias
    localparam logic [31:0] ALIAS = (g == 0) ? MEM_LO : MEM_HI;
    assign mem_hit[g] = !is_io && (addr == ALIAS[ADDR_W-1:0]);
  end

  assign hit = io_hit || (|mem_hit);
endmodule

// File: rtl/rsc_arm.sv
module rsc_arm
  import rsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_bits,
  output rst_kind_e        fire_kind,
  output logic [SEL_W-1:0] sel_q,
  output logic             armed_q
);
  logic trig;
  logic match;

  assign trig  = wr_bits[TRIG_BIT];
  assign match = (wr_bits[SEL_W-1:0] == sel_q);

  always_comb begin
    fire_kind = RK_NONE;
    if (wr_en && trig && armed_q && match)
      fire_kind = sel_q[HARD_BIT] ? RK_HARD : RK_SOFT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      sel_q   <= '0;
    end else if (wr_en) begin
      if (!trig) begin
        sel_q   <= wr_bits[SEL_W-1:0];
        armed_q <= 1'b1;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  AST_IDLE_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !wr_en) |=> (armed_q && $stable(sel_q))); // R7
  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_kind != RK_NONE) |=> !armed_q); // R12
  AST_MISMATCH_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && trig && !match) |=> (!armed_q && $stable(sel_q))); // R6
  AST_UNARMED_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q) |-> (fire_kind == RK_NONE)); // R5
endmodule

// File: rtl/rsc_pulse.sv
module rsc_pulse #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             active
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= len - CNT_W'(1);
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !start); // R9
  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |=> active); // R2
endmodule

// File: rtl/sysreset_seq.sv
module sysreset_seq
  import rsc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned MIN_HARD = 16,
  parameter int unsigned INIT_LEN = 4,
  parameter logic [15:0] IO_ADDR  = 16'hCF9,
  parameter logic [31:0] MEM_LO   = 32'hFFFF_FFF0,
  parameter logic [31:0] MEM_HI   = 32'hFFFF_FFF4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_is_io,
  input  logic [LEN_W-1:0]  hard_len,
  output logic [7:0]        sel_rd_o,
  output logic              cpu_reset_o,
  output logic              pci_reset_o,
  output logic              xbus_reset_o,
  output logic              cpu_init_o
);
  localparam int unsigned RUN_W = LEN_W + 1;

  logic                 hit;
  logic                 wr_en;
  rst_kind_e            fire_kind;
  logic [SEL_W-1:0]     sel_q;
  logic                 armed_q;
  logic [NUM_PULSE-1:0] act;
  logic [LEN_W-1:0]     hard_eff;
  logic                 unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:3];

  rsc_decode #(
    .ADDR_W (ADDR_W),
    .IO_ADDR(IO_ADDR),
    .MEM_LO (MEM_LO),
    .MEM_HI (MEM_HI)
  ) u_dec (
    .addr (wr_addr),
    .is_io(wr_is_io),
    .hit  (hit)
  );

  assign wr_ready = !(|act);
  assign wr_en    = wr_valid && wr_ready && hit;

  rsc_arm u_arm (
    .clk      (clk),
    .rst_n    (por_n),
    .wr_en    (wr_en),
    .wr_bits  (wr_data[2:0]),
    .fire_kind(fire_kind),
    .sel_q    (sel_q),
    .armed_q  (armed_q)
  );

  assign hard_eff = (hard_len < LEN_W'(MIN_HARD)) ? LEN_W'(MIN_HARD) : hard_len;

  for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
    logic             start_g;
    logic [LEN_W-1:0] len_g;
    if (g == 0) begin : g_hard
      assign start_g = (fire_kind == RK_HARD);
      assign len_g   = hard_eff;
    end else begin : g_init
      assign start_g = (fire_kind == RK_SOFT);
      assign len_g   = LEN_W'(INIT_LEN);
    end
    rsc_pulse #(.CNT_W(LEN_W)) u_pulse (
      .clk   (clk),
      .rst_n (por_n),
      .start (start_g),
      .len   (len_g),
      .active(act[g])
    );
  end

  assign cpu_reset_o  = act[0];
  assign pci_reset_o  = act[0];
  assign xbus_reset_o = act[0];
  assign cpu_init_o   = act[1];
  assign sel_rd_o     = {6'b0, sel_q};

  // run-length monitors for the pulse-width checks
  logic [RUN_W-1:0] hard_run_q;
  logic [RUN_W-1:0] init_run_q;
  always_ff @(posedge clk) begin
    if (!por_n) begin
      hard_run_q <= '0;
      init_run_q <= '0;
    end else begin
      hard_run_q <= act[0] ? hard_run_q + RUN_W'(1) : '0;
      init_run_q <= act[1] ? init_run_q + RUN_W'(1) : '0;
    end
  end

  AST_KINDS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!por_n)
    !(act[0] && act[1])); // R3
  AST_HARD_FLOOR: assert property (@(posedge clk) disable iff (!por_n)
    $fell(act[0]) |-> (hard_run_q >= RUN_W'(MIN_HARD))); // R8
  AST_INIT_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
    $fell(act[1]) |-> (init_run_q == RUN_W'(INIT_LEN))); // R3
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!por_n)
    (act != '0) |=> $stable(sel_q)); // R9
  AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    sel_rd_o[7:2] == 6'b0); // R10
endmodule

// File: tb/sysreset_seq_test.sv
module sysreset_seq_test;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_is_io = 1'b0;
  logic [7:0]  hard_len = 8'd20;
  logic [7:0]  sel_rd_o;
  logic        cpu_reset_o, pci_reset_o, xbus_reset_o, cpu_init_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [31:0] IOP = 32'h0000_0CF9;
  localparam logic [31:0] MLO = 32'hFFFF_FFF0;
  localparam logic [31:0] MHI = 32'hFFFF_FFF4;

  always #5 clk = ~clk;

  sysreset_seq uut (
    .clk(clk), .por_n(por_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_is_io(wr_is_io),
    .hard_len(hard_len), .sel_rd_o(sel_rd_o), .cpu_reset_o(cpu_reset_o),
    .pci_reset_o(pci_reset_o), .xbus_reset_o(xbus_reset_o),
    .cpu_init_o(cpu_init_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit io);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_is_io = io; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // called right after a trigger write; counts high cycles until idle
  task automatic measure(output int hn, output int in_n, output int skew);
    hn = 0; in_n = 0; skew = 0;
    for (int i = 0; i < 300; i++) begin
      if (cpu_reset_o) hn++;
      if (cpu_init_o) in_n++;
      if (pci_reset_o != cpu_reset_o || xbus_reset_o != cpu_reset_o) skew++;
      if (!cpu_reset_o && !cpu_init_o) break;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cpu_reset_o || pci_reset_o || xbus_reset_o || cpu_init_o) hits++;
    end
    check(hits == 0, req, hits, 0);
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic t_reset_state();
    check(sel_rd_o == 8'h00, "R10", sel_rd_o, 0);
    check(!cpu_reset_o && !cpu_init_o, "R10", cpu_reset_o, 0);
    check(wr_ready == 1'b1, "R9", wr_ready, 1);
  endtask

  task automatic t_hard_io();
    int h, n, s;
    hard_len = 8'd20;
    wr(IOP, 32'h02, 1'b1);
    check(sel_rd_o == 8'h02, "R1", sel_rd_o, 2);
    check(!cpu_reset_o && !cpu_init_o, "R1", cpu_reset_o, 0);
    wr(IOP, 32'h06, 1'b1);
    measure(h, n, s);
    check(h == 20, "R2", h, 20);
    check(n == 0, "R2", n, 0);
    check(s == 0, "R2", s, 0);
  endtask

  task automatic t_soft_io();
    int h, n, s;
    wr(IOP, 32'h00, 1'b1);
    check(sel_rd_o == 8'h00, "R1", sel_rd_o, 0);
    wr(IOP, 32'h04, 1'b1);
    measure(h, n, s);
    check(n == 4, "R3", n, 4);
    check(h == 0, "R3", h, 0);
  endtask

  task automatic t_mem_alias();
    int h, n, s;
    wr(MLO, 32'h02, 1'b0);
    check(sel_rd_o == 8'h02, "R4", sel_rd_o, 2);
    wr(MHI, 32'h06, 1'b0);
    measure(h, n, s);
    check(h == 20 && s == 0, "R4", h, 20);
  endtask

  task automatic t_unarmed();
    do_por();
    wr(IOP, 32'h06, 1'b1);
    quiet(6, "R5");
  endtask

  task automatic t_mismatch();
    wr(IOP, 32'h02, 1'b1);
    wr(IOP, 32'h04, 1'b1);
    quiet(4, "R6");
    check(sel_rd_o == 8'h02, "R6", sel_rd_o, 2);
    wr(IOP, 32'h06, 1'b1);
    quiet(6, "R6");
  endtask

  task automatic t_other_writes();
    int h, n, s;
    wr(IOP, 32'h02, 1'b1);
    wr(32'h0000_0CF8, 32'h04, 1'b1);
    wr(IOP, 32'h00, 1'b0);
    wr(MLO, 32'h05, 1'b1);
    wr(32'h1234_5678, 32'hFF, 1'b0);
    check(sel_rd_o == 8'h02, "R7", sel_rd_o, 2);
    check(!cpu_reset_o && !cpu_init_o, "R7", cpu_init_o, 0);
    wr(IOP, 32'h06, 1'b1);
    measure(h, n, s);
    check(h == 20, "R7", h, 20);
  endtask

  task automatic t_clamp();
    int h, n, s;
    hard_len = 8'd5;
    wr(IOP, 32'h02, 1'b1);
    wr(IOP, 32'h06, 1'b1);
    measure(h, n, s);
    check(h == 16, "R8", h, 16);
    hard_len = 8'd20;
  endtask

  task automatic t_busy();
    int h, n, s;
    wr(IOP, 32'h02, 1'b1);
    wr(IOP, 32'h06, 1'b1);
    wr_addr = IOP; wr_data = 32'h00; wr_is_io = 1'b1; wr_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check(wr_ready == 1'b0, "R9", wr_ready, 0);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    check(sel_rd_o == 8'h02, "R9", sel_rd_o, 2);
    measure(h, n, s);
    check(h == 17, "R9", h, 17);
    check(wr_ready == 1'b1, "R9", wr_ready, 1);
  endtask

  task automatic t_por_clear();
    wr(IOP, 32'h03, 1'b1);
    check(sel_rd_o == 8'h03, "R10", sel_rd_o, 3);
    do_por();
    check(sel_rd_o == 8'h00, "R10", sel_rd_o, 0);
    wr(IOP, 32'h07, 1'b1);
    quiet(6, "R10");
  endtask

  task automatic t_upper_bits();
    int h, n, s;
    wr(IOP, 32'hABCD_00FA, 1'b1);
    check(sel_rd_o == 8'h02, "R11", sel_rd_o, 2);
    wr(IOP, 32'h5500_00F6, 1'b1);
    measure(h, n, s);
    check(h == 20, "R11", h, 20);
  endtask

  task automatic t_no_refire();
    int h, n, s;
    wr(IOP, 32'h00, 1'b1);
    wr(IOP, 32'h04, 1'b1);
    measure(h, n, s);
    check(n == 4, "R12", n, 4);
    wr(IOP, 32'h04, 1'b1);
    quiet(6, "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_hard_io();
    t_soft_io();
    t_mem_alias();
    t_unarmed();
    t_mismatch();
    t_other_writes();
    t_clamp();
    t_busy();
    t_por_clear();
    t_upper_bits();
    t_no_refire();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule